// File: doc/BRIEF.md
# Drift-Trimmed Nanosecond Time Counter

This block keeps a 64-bit count of nanoseconds for a network timestamp unit. On every clock it normally advances by 16 ns. A drift corrector trims the rate. At a programmable interval it folds a small correction of 0 to 7 ns into one cycle's increment, either adding it or taking it away. The live count is driven out continuously so that a packet timestamp latch can capture it.

Software reaches the block through a plain register port with valid, write, address and data lines. Through this port it can pause the counter, load it in two 32-bit halves while it is paused, resume it, and read it back in two halves. It also programs the drift word. A drift word only takes effect while a separate drift-hold bit is set. Software sets the hold bit, reads it back, writes the word, then clears the hold bit to start the corrector.

Top module: `tod_counter`

## Requirements
- R1: After reset the count is zero and running, the drift word reads 0 and the drift-hold bit (address 6, bit 0) reads 0.
- R2: While running with no correction due, the count rises by exactly 16 on each clock.
- R3: The drift word at address 5 carries the direction in bit 31 (1 adds, 0 subtracts), the magnitude in ns in bits 30:28 and the interval in 16 ns units in bits 27:0. A period of 0 counts as 1. A correction falls due each time the nominal time elapsed reaches period×16+8 ns, and it changes that cycle's increment by the magnitude.
- R4: While the drift-hold bit is 1, the interval tracker is held cleared and no correction is applied. The bit reads back at address 6, bit 0.
- R5: Writing 2 to the control register (address 4) freezes the count from the next clock. Writing 4 resumes it from the next clock. Any other value has no effect.
- R6: While paused, writes to address 2 replace bits 31:0 of the count and writes to address 3 replace bits 63:32. While running, these writes are ignored.
- R7: Reading address 0 returns bits 31:0 of the count and captures bits 63:32. A following read of address 1 returns the captured half, even if the live upper half has since moved.
- R8: A write to the drift word while the drift-hold bit is 0 is ignored. The word reads back at address 5.
- R9: A drift word with magnitude 0, including an all-zero word, applies no correction.
- R10: `time_o` always shows the live count. Read data appears on `reg_rdata_o` one clock after the read request, taken from the count as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one tick per 16 ns nominal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access request |
| reg_write_i | input | 1 | 1 for write, 0 for read |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered |
| time_o | output | 64 | Live nanosecond count |

## Verification
The low half of the count wrapping into the upper half can land on the same clock as a low-half read. The bench provokes this by pausing the count, loading it 16 ns below a carry, resuming it and then issuing the two reads back to back. The upper-half read must return the captured value rather than the already incremented live value, and `time_o` must show the carried count. A drift correction falling due on the same cycle as the nominal step is judged by measuring the count over whole correction periods and comparing the result with the step sum worked out by hand.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  typedef enum logic [2:0] {
    A_TIME_LO   = 3'd0,
    A_TIME_HI   = 3'd1,
    A_LOAD_LO   = 3'd2,
    A_LOAD_HI   = 3'd3,
    A_CTRL      = 3'd4,
    A_DRIFT_CFG = 3'd5,
    A_DRIFT_RST = 3'd6
  } reg_addr_e;

  localparam logic [31:0] CTRL_PAUSE  = 32'd2;
  localparam logic [31:0] CTRL_RESUME = 32'd4;

  typedef struct packed {
    logic        dir;     // 1: add
    logic [2:0]  mag;     // ns
    logic [27:0] period;  // 16 ns units
  } drift_cfg_t;
endpackage

// File: rtl/tod_drift_gen.sv
`timescale 1ns/1ps
module tod_drift_gen #(
  parameter int PER_W   = 28,
  parameter int MAG_W   = 3,
  parameter int NOM_INC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic             due_o
);
  localparam int ACC_W = PER_W + 6;

  logic [ACC_W-1:0] acc_q, acc_sum, interval;
  logic [PER_W-1:0] per_eff;
  logic             active;

  always_comb begin
    per_eff  = (period_i == '0) ? PER_W'(1) : period_i;
    interval = (ACC_W'(per_eff) << 4) + ACC_W'(8);
    acc_sum  = acc_q + ACC_W'(NOM_INC);
    active   = (mag_i != '0) && !hold_i;
    due_o    = run_i && active && (acc_sum >= interval);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (!active) acc_q <= '0;
    else if (run_i)   acc_q <= due_o ? (acc_sum - interval) : acc_sum;
  end
endmodule

// File: rtl/tod_time_core.sv
`timescale 1ns/1ps
module tod_time_core #(
  parameter int TIME_W  = 64,
  parameter int HALF_W  = 32,
  parameter int MAG_W   = 3,
  parameter int NOM_INC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [HALF_W-1:0] ld_data_i,
  input  logic              due_i,
  input  logic              add_i,
  input  logic [MAG_W-1:0]  mag_i,
  output logic [TIME_W-1:0] time_o
);
  localparam int HI_W = TIME_W - HALF_W;

  logic [TIME_W-1:0] time_q, step;

  always_comb begin
    step = TIME_W'(NOM_INC);
    if (due_i) step = add_i ? step + TIME_W'(mag_i) : step - TIME_W'(mag_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else if (run_i) time_q <= time_q + step;
    else begin
      if (ld_lo_i) time_q[HALF_W-1:0]      <= ld_data_i;
      if (ld_hi_i) time_q[TIME_W-1:HALF_W] <= HI_W'(ld_data_i);
    end
  end

  assign time_o = time_q;
endmodule

// File: rtl/tod_rd_port.sv
`timescale 1ns/1ps
module tod_rd_port
  import tod_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int HALF_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [2:0]        addr_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [HALF_W-1:0] cfg_i,
  input  logic              hold_i,
  output logic [HALF_W-1:0] rdata_o
);
  localparam int HI_W = TIME_W - HALF_W;

  logic [HI_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      snap_q  <= '0;
    end else if (re_i) begin
      case (reg_addr_e'(addr_i))
        A_TIME_LO: begin
          rdata_o <= time_i[HALF_W-1:0];
          snap_q  <= time_i[TIME_W-1:HALF_W];
        end
        A_TIME_HI:   rdata_o <= HALF_W'(snap_q);
        A_DRIFT_CFG: rdata_o <= cfg_i;
        A_DRIFT_RST: rdata_o <= HALF_W'(hold_i);
        default:     rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter
  import tod_pkg::*;
#(
  parameter int TIME_W  = 64,
  parameter int DATA_W  = 32,
  parameter int NOM_INC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [TIME_W-1:0] time_o
);
  localparam int PER_W = $bits(drift_cfg_t) - 4;
  localparam int MAG_W = 3;

  logic       paused_q, drift_rst_q, corr_due;
  drift_cfg_t cfg_q;
  logic       we, re, ctrl_wr, cfg_wr, rst_wr, ld_lo_wr, ld_hi_wr, load_we;

  always_comb begin
    we       = reg_valid_i && reg_write_i;
    re       = reg_valid_i && !reg_write_i;
    ctrl_wr  = we && (reg_addr_i == A_CTRL);
    cfg_wr   = we && (reg_addr_i == A_DRIFT_CFG);
    rst_wr   = we && (reg_addr_i == A_DRIFT_RST);
    ld_lo_wr = we && (reg_addr_i == A_LOAD_LO);
    ld_hi_wr = we && (reg_addr_i == A_LOAD_HI);
    load_we  = ld_lo_wr || ld_hi_wr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paused_q    <= 1'b0;
      drift_rst_q <= 1'b0;
      cfg_q       <= '0;
    end else begin
      if (ctrl_wr && reg_wdata_i == CTRL_PAUSE)  paused_q <= 1'b1;
      if (ctrl_wr && reg_wdata_i == CTRL_RESUME) paused_q <= 1'b0;
      if (rst_wr)                cfg_q       <= cfg_q;
      if (rst_wr)                drift_rst_q <= reg_wdata_i[0];
      if (cfg_wr && drift_rst_q) cfg_q       <= drift_cfg_t'(reg_wdata_i);
    end
  end

  tod_drift_gen #(
    .PER_W(PER_W), .MAG_W(MAG_W), .NOM_INC(NOM_INC)
  ) u_drift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (!paused_q),
    .hold_i   (drift_rst_q),
    .period_i (cfg_q.period),
    .mag_i    (cfg_q.mag),
    .due_o    (corr_due)
  );

  tod_time_core #(
    .TIME_W(TIME_W), .HALF_W(DATA_W), .MAG_W(MAG_W), .NOM_INC(NOM_INC)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (!paused_q),
    .ld_lo_i   (ld_lo_wr),
    .ld_hi_i   (ld_hi_wr),
    .ld_data_i (reg_wdata_i),
    .due_i     (corr_due),
    .add_i     (cfg_q.dir),
    .mag_i     (cfg_q.mag),
    .time_o    (time_o)
  );

  tod_rd_port #(
    .TIME_W(TIME_W), .HALF_W(DATA_W)
  ) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (re),
    .addr_i  (reg_addr_i),
    .time_i  (time_o),
    .cfg_i   (cfg_q),
    .hold_i  (drift_rst_q),
    .rdata_o (reg_rdata_o)
  );
endmodule

// File: rtl/tod_counter_chk.sv
`timescale 1ns/1ps
module tod_counter_chk #(
  parameter int TIME_W  = 64,
  parameter int NOM_INC = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              paused_i,
  input logic              load_we_i,
  input logic              due_i,
  input logic              add_i,
  input logic [2:0]        mag_i,
  input logic              hold_i,
  input logic              cfg_we_i,
  input logic [31:0]       cfg_i,
  input logic [TIME_W-1:0] time_i
);
  // R2
  free_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!paused_i && !due_i) |=> time_i == $past(time_i) + TIME_W'(NOM_INC));

  // R3
  corr_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!paused_i && due_i && add_i) |=>
      time_i == $past(time_i) + TIME_W'(NOM_INC) + TIME_W'($past(mag_i)));

  // R4
  hold_no_corr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !due_i);

  // R5
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_i && !load_we_i) |=> $stable(time_i));

  // R8
  cfg_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !hold_i) |=> $stable(cfg_i));

  // R9
  mag_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_i == 3'd0) |-> !due_i);
endmodule

bind tod_counter tod_counter_chk #(.TIME_W(TIME_W), .NOM_INC(NOM_INC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .paused_i  (paused_q),
  .load_we_i (load_we),
  .due_i     (corr_due),
  .add_i     (cfg_q.dir),
  .mag_i     (cfg_q.mag),
  .hold_i    (drift_rst_q),
  .cfg_we_i  (cfg_wr),
  .cfg_i     (cfg_q),
  .time_i    (time_o)
);

// File: tb/tod_counter_bench.sv
`timescale 1ns/1ps
module tod_counter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_valid_i = 1'b0;
  logic        reg_write_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [63:0] time_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  tod_counter u_tod_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_valid_i(reg_valid_i),
    .reg_write_i(reg_write_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .time_o(time_o)
  );

  localparam logic [2:0] TLO = 3'd0, THI = 3'd1, LLO = 3'd2, LHI = 3'd3,
                         CTL = 3'd4, CFG = 3'd5, DRS = 3'd6;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    reg_valid_i = 1'b0; reg_write_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    reg_valid_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic measure(input int n, output logic [63:0] delta);
    logic [63:0] t0;
    t0 = time_o;
    repeat (n) @(negedge clk_i);
    delta = time_o - t0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 time at reset", time_o, 64'd0);
    rd(DRS, d); chk("R1 drift hold at reset", 64'(d), 64'd0);
    rd(CFG, d); chk("R1 drift word at reset", 64'(d), 64'd0);
  endtask

  task automatic t_free_run();
    logic [63:0] dl;
    logic [63:0] pre;
    logic [31:0] d;
    measure(10, dl); chk("R2 ten cycles", dl, 64'd160);
    pre = time_o;
    rd(TLO, d); chk("R10 low read matches live count", 64'(d), 64'(pre[31:0]));
  endtask

  task automatic t_pause_load();
    logic [63:0] t0, dl;
    wr(CTL, 32'd2);
    t0 = time_o;
    measure(5, dl); chk("R5 paused count frozen", dl, 64'd0);
    wr(LLO, 32'h1234_5678);
    wr(LHI, 32'h0000_00AB);
    chk("R6 load while paused", time_o, 64'h0000_00AB_1234_5678);
    wr(CTL, 32'd4);
    chk("R5 resume edge still held", time_o, 64'h0000_00AB_1234_5678);
    @(negedge clk_i);
    chk("R5 running after resume", time_o, 64'h0000_00AB_1234_5688);
  endtask

  task automatic t_ctrl_other();
    logic [63:0] t0;
    t0 = time_o;
    wr(CTL, 32'd3);
    @(negedge clk_i);
    chk("R5 other control value ignored", time_o - t0, 64'd32);
  endtask

  task automatic t_load_running();
    logic [63:0] t0;
    t0 = time_o;
    wr(LLO, 32'd0);
    wr(LHI, 32'd0);
    chk("R6 load ignored while running", time_o - t0, 64'd32);
  endtask

  task automatic t_snapshot();
    logic [31:0] d;
    wr(CTL, 32'd2);
    wr(LLO, 32'hFFFF_FFF0);
    wr(LHI, 32'h0000_0005);
    wr(CTL, 32'd4);
    rd(TLO, d); chk("R7 low half before carry", 64'(d), 64'hFFFF_FFF0);
    rd(THI, d); chk("R7 high half from snapshot", 64'(d), 64'h5);
    chk("R7 live count carried", time_o, 64'h0000_0006_0000_0010);
  endtask

  task automatic t_drift_add();
    logic [31:0] d;
    logic [63:0] dl;
    wr(DRS, 32'd1);
    rd(DRS, d); chk("R4 hold bit reads back", 64'(d), 64'd1);
    wr(CFG, 32'hD000_0001);
    rd(CFG, d); chk("R3 drift word reads back", 64'(d), 64'hD000_0001);
    measure(6, dl); chk("R4 no correction while held", dl, 64'd96);
    wr(DRS, 32'd0);
    measure(6, dl); chk("R3 add 5 ns every 24 ns", dl, 64'd116);
  endtask

  task automatic t_cfg_ignored();
    logic [31:0] d;
    logic [63:0] dl;
    wr(CFG, 32'h3000_0001);
    rd(CFG, d); chk("R8 word write ignored when not held", 64'(d), 64'hD000_0001);
    measure(6, dl); chk("R8 rate unchanged", dl, 64'd116);
  endtask

  task automatic t_drift_sub();
    logic [63:0] dl;
    wr(DRS, 32'd1); wr(CFG, 32'h3000_0001); wr(DRS, 32'd0);
    measure(6, dl); chk("R3 subtract 3 ns every 24 ns", dl, 64'd84);
  endtask

  task automatic t_drift_p2();
    logic [63:0] dl;
    wr(DRS, 32'd1); wr(CFG, 32'hF000_0002); wr(DRS, 32'd0);
    measure(10, dl); chk("R3 add 7 ns every 40 ns", dl, 64'd188);
  endtask

  task automatic t_mag_zero();
    logic [63:0] dl;
    wr(DRS, 32'd1); wr(CFG, 32'h8000_0001); wr(DRS, 32'd0);
    measure(6, dl); chk("R9 magnitude zero", dl, 64'd96);
    wr(DRS, 32'd1); wr(CFG, 32'h0); wr(DRS, 32'd0);
    measure(6, dl); chk("R9 all-zero word", dl, 64'd96);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_free_run();
    t_pause_load();
    t_ctrl_other();
    t_load_running();
    t_snapshot();
    t_drift_add();
    t_cfg_ignored();
    t_drift_sub();
    t_drift_p2();
    t_mag_zero();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule